// File: doc/BRIEF.md
# Link-Down Containment Guard

This block sits beside a four-lane chip-to-chip serial link and enforces a one-way safety policy on it. It follows the data-link-up indication through a small state machine. Once the link has come up at least once, a later loss of the link is treated as fatal. From that point the guard blocks every retrain request and discards every completion coming back upstream. It also holds back every downstream handshake that had not completed before the loss was seen. Only a global reset clears this condition, because a silent retrain could corrupt data.

Errors are reported on one line only: a system-error pulse that lasts one cycle. A status word shows which error kinds have occurred, together with a fixed function number that all of the link's errors are charged to. The link may only run four lanes wide. A width request with any other lane count is refused and recorded.

Top module: `link_fatal_guard`

## Requirements
- R1: After reset, `stat_o` is all zeros, `serr_o` and `width_nak_o` are low, and the guard waits for the first link-up.
- R2: While the link has not yet been up, a low `link_up_i` is not fatal: no system-error pulse, status bit 0 stays clear, retraining stays allowed.
- R3: When `link_up_i` is sampled low at a clock edge while the link is up, the guard becomes fatal. `serr_o` is high for exactly the one cycle after that edge, and status bit 0 is set from the same edge.
- R4: The fatal state is left only through `rst_n`. Later link-up or link-down values produce no further `serr_o` pulse and do not clear status bit 0.
- R5: `retrain_en_o` equals `retrain_req_i` in the same cycle, except in the fatal state, where it is held low.
- R6: Outside the fatal state, `cpl_valid_o`/`cpl_data_o` follow `cpl_valid_i`/`cpl_data_i` in the same cycle and `cpl_drop_o` is low. In the fatal state, `cpl_valid_o` is low and `cpl_drop_o` equals `cpl_valid_i`.
- R7: `dn_fwd_o` is high only in a cycle where `dn_valid_i` and `dn_ready_i` are both high, the link is up, and `link_up_i` is high. A handshake in the cycle where the loss is sampled is not forwarded, and neither is any handshake before the first link-up or after the loss.
- R8: A width request (`width_req_vld_i` high) whose lane count `width_req_i` is not 4 raises `width_nak_o` for the following cycle and sets status bit 1. A request for 4 lanes raises neither.
- R9: Status layout: bit 0 is the sticky fatal flag and bit 1 is the sticky width-error flag. Bits [FUNC_W+1:2] read `ERR_FUNC` when either flag is set and zero otherwise.
- R10: A width error never pulses `serr_o`. Only entry into the fatal state does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| link_up_i | input | 1 | Data-link-up indication |
| retrain_req_i | input | 1 | Retrain request from link control |
| retrain_en_o | output | 1 | Gated retrain enable |
| width_req_vld_i | input | 1 | Width request strobe |
| width_req_i | input | LANE_W | Requested lane count |
| width_nak_o | output | 1 | Width request refused (one cycle) |
| cpl_valid_i | input | 1 | Upstream completion valid |
| cpl_data_i | input | DATA_W | Upstream completion payload |
| cpl_valid_o | output | 1 | Forwarded completion valid |
| cpl_data_o | output | DATA_W | Forwarded completion payload |
| cpl_drop_o | output | 1 | Completion discarded this cycle |
| dn_valid_i | input | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request ready |
| dn_fwd_o | output | 1 | Downstream request counted as transmitted |
| serr_o | output | 1 | System-error pulse |
| stat_o | output | FUNC_W+2 | Status word |

## Verification
Most state errors reach the ports within one cycle. If the state machine sits in the wrong state, the gates on `retrain_en_o`, `cpl_valid_o` and `dn_fwd_o` flip in the same cycle the bench drives a request. A wrong or missing fatal entry shows one edge later on `serr_o` and status bit 0. A fatal state that leaks out, or a sticky bit that clears, shows when the link comes back up. A wrong width decision shows on `width_nak_o` in the cycle after the request.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
   typedef enum logic [1:0] {
      LS_RESET   = 2'd0,
      LS_WAIT_UP = 2'd1,
      LS_UP      = 2'd2,
      LS_DEAD    = 2'd3
   } lfg_state_e;
endpackage

// File: rtl/lfg_link_fsm.sv
module lfg_link_fsm
   import lfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       link_up_i,
   output lfg_state_e state_o,
   output logic       enter_dead_o
);
   lfg_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LS_RESET:   state_d = LS_WAIT_UP;
         LS_WAIT_UP: if (link_up_i) state_d = LS_UP;
         LS_UP:      if (!link_up_i) state_d = LS_DEAD;
         LS_DEAD:    state_d = LS_DEAD;
         default:    state_d = LS_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LS_RESET;
      else        state_q <= state_d;
   end

   assign state_o      = state_q;
   assign enter_dead_o = (state_q == LS_UP) && !link_up_i;

   // R4
   dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == LS_DEAD |=> state_q == LS_DEAD);
   // R2
   wait_not_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_WAIT_UP && !link_up_i) |=> state_q == LS_WAIT_UP);
endmodule

// File: rtl/lfg_cpl_filter.sv
module lfg_cpl_filter #(
   parameter int DATA_W = 32
) (
   input  logic              dead_i,
   input  logic              cpl_valid_i,
   input  logic [DATA_W-1:0] cpl_data_i,
   output logic              cpl_valid_o,
   output logic [DATA_W-1:0] cpl_data_o,
   output logic              cpl_drop_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("lfg_cpl_filter: DATA_W must be at least 1");
      end
   endgenerate

   always_comb begin
      cpl_valid_o = cpl_valid_i && !dead_i;
      cpl_drop_o  = cpl_valid_i && dead_i;
      cpl_data_o  = dead_i ? '0 : cpl_data_i;
   end
endmodule

// File: rtl/lfg_err_report.sv
module lfg_err_report #(
   parameter int          LANE_W      = 5,
   parameter int          LEGAL_LANES = 4,
   parameter int          FUNC_W      = 3,
   parameter int unsigned ERR_FUNC    = 0,
   localparam int         STAT_W      = FUNC_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_dead_i,
   input  logic              wreq_vld_i,
   input  logic [LANE_W-1:0] wreq_lanes_i,
   output logic              serr_o,
   output logic              wnak_o,
   output logic [STAT_W-1:0] stat_o
);
   localparam logic [LANE_W-1:0] LEGAL_V = LANE_W'(LEGAL_LANES);
   localparam logic [FUNC_W-1:0] FUNC_V  = FUNC_W'(ERR_FUNC);

   generate
      if (LEGAL_LANES >= (1 << LANE_W)) begin : g_bad_lanes
         $error("lfg_err_report: LEGAL_LANES does not fit LANE_W");
      end
      if (ERR_FUNC >= (1 << FUNC_W)) begin : g_bad_func
         $error("lfg_err_report: ERR_FUNC does not fit FUNC_W");
      end
   endgenerate

   logic serr_q, wnak_q, fatal_q, werr_q;
   logic bad_req;

   assign bad_req = wreq_vld_i && (wreq_lanes_i != LEGAL_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serr_q  <= 1'b0;
         wnak_q  <= 1'b0;
         fatal_q <= 1'b0;
         werr_q  <= 1'b0;
      end else begin
         serr_q  <= enter_dead_i && !fatal_q;
         wnak_q  <= bad_req;
         fatal_q <= fatal_q || enter_dead_i;
         werr_q  <= werr_q || bad_req;
      end
   end

   assign serr_o = serr_q;
   assign wnak_o = wnak_q;
   assign stat_o = {((fatal_q || werr_q) ? FUNC_V : '0), werr_q, fatal_q};

   // R3
   serr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serr_q |=> !serr_q);
   // R8
   width_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wreq_vld_i && wreq_lanes_i != LEGAL_V) |=> (wnak_o && stat_o[1]));
   // R10
   serr_only_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serr_o |-> stat_o[0]);
endmodule

// File: rtl/link_fatal_guard.sv
module link_fatal_guard
   import lfg_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          LANE_W      = 5,
   parameter int          LEGAL_LANES = 4,
   parameter int          FUNC_W      = 3,
   parameter int unsigned ERR_FUNC    = 0,
   localparam int         STAT_W      = FUNC_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up_i,
   input  logic              retrain_req_i,
   output logic              retrain_en_o,
   input  logic              width_req_vld_i,
   input  logic [LANE_W-1:0] width_req_i,
   output logic              width_nak_o,
   input  logic              cpl_valid_i,
   input  logic [DATA_W-1:0] cpl_data_i,
   output logic              cpl_valid_o,
   output logic [DATA_W-1:0] cpl_data_o,
   output logic              cpl_drop_o,
   input  logic              dn_valid_i,
   input  logic              dn_ready_i,
   output logic              dn_fwd_o,
   output logic              serr_o,
   output logic [STAT_W-1:0] stat_o
);
   lfg_state_e state;
   logic       enter_dead;
   logic       dead;

   lfg_link_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_up_i    (link_up_i),
      .state_o      (state),
      .enter_dead_o (enter_dead)
   );

   assign dead = (state == LS_DEAD);

   lfg_cpl_filter #(.DATA_W(DATA_W)) u_cpl (
      .dead_i      (dead),
      .cpl_valid_i (cpl_valid_i),
      .cpl_data_i  (cpl_data_i),
      .cpl_valid_o (cpl_valid_o),
      .cpl_data_o  (cpl_data_o),
      .cpl_drop_o  (cpl_drop_o)
   );

   lfg_err_report #(
      .LANE_W      (LANE_W),
      .LEGAL_LANES (LEGAL_LANES),
      .FUNC_W      (FUNC_W),
      .ERR_FUNC    (ERR_FUNC)
   ) u_err (
      .clk          (clk),
      .rst_n        (rst_n),
      .enter_dead_i (enter_dead),
      .wreq_vld_i   (width_req_vld_i),
      .wreq_lanes_i (width_req_i),
      .serr_o       (serr_o),
      .wnak_o       (width_nak_o),
      .stat_o       (stat_o)
   );

   assign retrain_en_o = retrain_req_i && !dead;
   assign dn_fwd_o     = dn_valid_i && dn_ready_i && (state == LS_UP) && link_up_i;

   // R5
   retrain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[0] |-> !retrain_en_o);
   // R6
   cpl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[0] |-> (!cpl_valid_o && (cpl_drop_o == cpl_valid_i)));
   // R7
   dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up_i || stat_o[0]) |-> !dn_fwd_o);
   // R3
   serr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serr_o |-> $rose(stat_o[0]));
endmodule

// File: tb/tb_link_fatal_guard.sv
`timescale 1ns/100ps
module tb_link_fatal_guard;
   localparam int DATA_W = 32;
   localparam int LANE_W = 5;
   localparam int FUNC_W = 3;
   localparam int FUNCV  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up = 0, rt_req = 0, w_vld = 0, cv = 0, dv = 0, dr = 0;
   logic [LANE_W-1:0] w_lanes = '0;
   logic [DATA_W-1:0] cd = '0;
   logic rt_en, w_nak, cv_o, c_drop, dn_fwd, serr;
   logic [DATA_W-1:0] cd_o;
   logic [FUNC_W+1:0] stat;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   link_fatal_guard #(.DATA_W(DATA_W), .LANE_W(LANE_W), .FUNC_W(FUNC_W),
                      .ERR_FUNC(FUNCV)) dut (
      .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .retrain_req_i(rt_req),
      .retrain_en_o(rt_en), .width_req_vld_i(w_vld), .width_req_i(w_lanes),
      .width_nak_o(w_nak), .cpl_valid_i(cv), .cpl_data_i(cd), .cpl_valid_o(cv_o),
      .cpl_data_o(cd_o), .cpl_drop_o(c_drop), .dn_valid_i(dv), .dn_ready_i(dr),
      .dn_fwd_o(dn_fwd), .serr_o(serr), .stat_o(stat));

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 0; link_up = 0; rt_req = 0; w_vld = 0; cv = 0; dv = 0; dr = 0;
      repeat (2) tick();
      rst_n = 1;
      tick();
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 stat", stat, 0);
      chk("R1 serr", serr, 0);
      chk("R1 nak", w_nak, 0);
   endtask

   task automatic t_wait_down();
      link_up = 0; rt_req = 1; dv = 1; dr = 1;
      #1;
      chk("R7 no fwd before up", dn_fwd, 0);
      repeat (4) tick();
      chk("R2 no serr", serr, 0);
      chk("R2 stat", stat, 0);
      chk("R2 retrain", rt_en, 1);
      rt_req = 0; dv = 0; dr = 0;
   endtask

   task automatic t_up_traffic();
      link_up = 1;
      repeat (2) tick();
      cv = 1; cd = 32'hCAFE_0123; rt_req = 1; dv = 1; dr = 1;
      #1;
      chk("R6 cpl valid", cv_o, 1);
      chk("R6 cpl data", cd_o, 32'hCAFE_0123);
      chk("R6 no drop", c_drop, 0);
      chk("R5 retrain up", rt_en, 1);
      chk("R7 fwd", dn_fwd, 1);
      dr = 0;
      #1;
      chk("R7 no ready", dn_fwd, 0);
      cv = 0; rt_req = 0; dv = 0;
   endtask

   task automatic t_width();
      w_vld = 1; w_lanes = 5'd4;
      tick();
      w_vld = 0;
      chk("R8 legal no nak", w_nak, 0);
      chk("R8 legal stat", stat, 0);
      w_vld = 1; w_lanes = 5'd8;
      tick();
      w_vld = 0;
      chk("R8 nak", w_nak, 1);
      chk("R9 stat width", stat, {3'(FUNCV), 1'b1, 1'b0});
      chk("R10 no serr", serr, 0);
      tick();
      chk("R8 nak one cycle", w_nak, 0);
   endtask

   task automatic t_fatal();
      link_up = 1; dv = 1; dr = 1;
      #1;
      chk("R7 fwd before loss", dn_fwd, 1);
      tick();
      link_up = 0;
      #1;
      chk("R7 same-cycle not fwd", dn_fwd, 0);
      chk("R3 not yet", serr, 0);
      tick();
      chk("R3 serr", serr, 1);
      chk("R3 stat bit0", stat[0], 1);
      chk("R9 func", stat[FUNC_W+1:2], FUNCV);
      rt_req = 1; cv = 1; cd = 32'h1234_5678;
      #1;
      chk("R5 retrain blocked", rt_en, 0);
      chk("R6 cpl blocked", cv_o, 0);
      chk("R6 drop", c_drop, 1);
      tick();
      chk("R3 pulse ends", serr, 0);
      link_up = 1;
      repeat (3) tick();
      chk("R4 no second serr", serr, 0);
      chk("R4 still fatal", stat[0], 1);
      chk("R4 retrain held", rt_en, 0);
      chk("R7 no fwd after", dn_fwd, 0);
      link_up = 0;
      repeat (2) tick();
      chk("R4 no serr on down", serr, 0);
      cv = 0; rt_req = 0; dv = 0; dr = 0;
   endtask

   task automatic t_recover();
      do_reset();
      chk("R4 reset clears", stat, 0);
      rt_req = 1;
      #1;
      chk("R5 retrain after reset", rt_en, 1);
      rt_req = 0;
   endtask

   task automatic t_fatal_only();
      link_up = 1;
      repeat (2) tick();
      link_up = 0;
      repeat (2) tick();
      chk("R9 fatal only", stat, {3'(FUNCV), 1'b0, 1'b1});
   endtask

   initial begin
      t_reset_state();
      t_wait_down();
      t_up_traffic();
      t_width();
      t_fatal();
      t_recover();
      t_fatal_only();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule